// File: doc/BRIEF.md
# Probe-Triggered Capture Core on a Chained Register Bus

This core watches four probe inputs: three single-bit probes and one 4-bit probe. It holds a trigger condition built from a per-probe operator and argument. Once it is armed and that condition holds, it stores a window of probe samples in an internal buffer. A signed trigger position chooses how many of the stored samples come from before the trigger cycle.

All control and readout uses a 16-bit register bus. The bus enters the core on one set of ports and leaves it, one clock later, on a matching set of ports, so several cores can sit in a chain. Each core claims only the window of addresses that starts at its base address. The window holds ten configuration words followed by one word per buffer entry. Every other transaction passes through the core untouched.

Top module: `la_core`

## Requirements
- R1: Every request cycle (`in_vld`=1) produces exactly one cycle with `out_vld`=1, one clock later, carrying the same address, write data and write flag. No `out_vld` is produced without a request.
- R2: A request whose address lies outside [BASE_ADDR, BASE_ADDR+10+DEPTH-1] leaves `out_rdata` equal to the incoming `in_rdata` and changes no state.
- R3: Window offsets are: 0 state, 1 trigger position, then 2+2k for the operator and 3+2k for the argument of probe k, with probe order a, b, c, d. A write (`in_we`=1) to an offset from 1 to 9 stores `in_wdata` and forwards `in_rdata`. A read returns the stored word on `out_rdata`.
- R4: The trigger position is kept as a signed 16-bit word: writing -69 reads back 0xFFBB.
- R5: The state word reads 0 idle, 1 armed, 2 capturing, 3 done. Writing 1 arms the core from idle or done. Writing 0 returns it to idle from any state. Any other written value has no effect.
- R6: While idle, a probe match starts no capture: the state stays 0 and the buffer is unchanged.
- R7: Operator codes are 8 equal, 9 not equal, 10 greater than, 11 less than, with the probe as the left operand of an unsigned comparison against the argument's low bits. Code 0 and every other code disable that probe.
- R8: The trigger fires in an armed cycle when every enabled probe compares true. With no probe enabled, it fires in the first armed cycle.
- R9: Let T be the negated trigger position clamped to [0, DEPTH-1], or 0 if the position is not negative. Entry T holds the trigger-cycle sample. Entry T-j holds the sample from j cycles earlier, and entry T+j the sample from j cycles later. The state becomes done once entry DEPTH-1 is written.
- R10: Reading offset 10+i returns buffer entry i with probe a in bit 0, b in bit 1, c in bit 2, d in bits 6:3, and zeros above. Writes to buffer offsets are ignored.
- R11: After reset the state is idle, the trigger position and all probe words are 0, and `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_a | input | 1 | Probe a |
| probe_b | input | 1 | Probe b |
| probe_c | input | 1 | Probe c |
| probe_d | input | 4 | Probe d |
| in_addr | input | 16 | Incoming bus address |
| in_wdata | input | 16 | Incoming write data |
| in_rdata | input | 16 | Incoming read data from upstream |
| in_we | input | 1 | Incoming write flag (1 = write) |
| in_vld | input | 1 | Incoming request strobe |
| out_addr | output | 16 | Forwarded address |
| out_wdata | output | 16 | Forwarded write data |
| out_rdata | output | 16 | Read data, replaced on a hit read |
| out_we | output | 1 | Forwarded write flag |
| out_vld | output | 1 | Forwarded request strobe |

## Verification
The bench sets a negative trigger position and drives a counting probe pattern. It then checks every buffer entry against the recorded history. A core that placed the trigger at the wrong index, or that lost the pre-trigger samples, would show every entry shifted. A positive position must behave as zero, and a core that used it as an index would return pre-trigger values in entry 0. The bench makes each comparison operator both hold and fail, gives an unknown code, and gives a partial match across two probes. A core that decoded operators loosely, or ORed the probe results, would leave the armed state early. The bench also checks that idle matches, invalid state values, writes to buffer offsets and out-of-window traffic all leave the observable state alone.

// File: rtl/la_pkg.sv
package la_pkg;
  localparam int NPROBE = 4;
  localparam int SW     = 7;
  localparam int NCFG   = 2 + 2 * NPROBE;

  function automatic int pw(input int k);
    return (k == NPROBE - 1) ? 4 : 1;
  endfunction

  function automatic int poff(input int k);
    return k;
  endfunction

  localparam logic [15:0] OP_EQ = 16'd8;
  localparam logic [15:0] OP_NE = 16'd9;
  localparam logic [15:0] OP_GT = 16'd10;
  localparam logic [15:0] OP_LT = 16'd11;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DONE  = 2'd3
  } st_e;
endpackage

// File: rtl/la_cmp.sv
module la_cmp #(
  parameter int W = 1
) (
  input  logic [15:0]  op,
  input  logic [W-1:0] arg,
  input  logic [W-1:0] val,
  output logic         en,
  output logic         hit
);
  import la_pkg::*;

  always_comb begin
    en  = 1'b1;
    hit = 1'b0;
    case (op)
      OP_EQ:   hit = (val == arg);
      OP_NE:   hit = (val != arg);
      OP_GT:   hit = (val > arg);
      OP_LT:   hit = (val < arg);
      default: en  = 1'b0;
    endcase
  end
endmodule

// File: rtl/la_buf.sv
module la_buf #(
  parameter int DEPTH = 128,
  parameter int W     = 7
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/la_capture.sv
module la_capture #(
  parameter int DEPTH = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arm_req,
  input  logic                     stop_req,
  input  logic                     trig,
  input  logic [15:0]              trig_loc,
  output la_pkg::st_e              state,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] wr_addr,
  output logic [$clog2(DEPTH)-1:0] base_ptr
);
  import la_pkg::*;
  localparam int AW = $clog2(DEPTH);

  st_e           state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d, base_q, base_d, left_q, left_d, tpos;
  logic [16:0]   mag;

  // trigger index inside the window
  always_comb begin
    mag = 17'd0 - {trig_loc[15], trig_loc};
    if (!trig_loc[15])                tpos = '0;
    else if (mag > 17'(DEPTH - 1))    tpos = AW'(DEPTH - 1);
    else                              tpos = mag[AW-1:0];
  end

  assign wr_en = (state_q == ST_ARMED) || (state_q == ST_CAPT);

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    base_d  = base_q;
    left_d  = left_q;
    if (wr_en) ptr_d = ptr_q + 1'b1;
    case (state_q)
      ST_ARMED: if (trig) begin
        base_d  = ptr_q - tpos;
        left_d  = AW'(DEPTH - 1) - tpos;
        state_d = (left_d == '0) ? ST_DONE : ST_CAPT;
      end
      ST_CAPT: begin
        left_d = left_q - 1'b1;
        if (left_q == AW'(1)) state_d = ST_DONE;
      end
      default: ;
    endcase
    if (stop_req)
      state_d = ST_IDLE;
    else if (arm_req && (state_q == ST_IDLE || state_q == ST_DONE))
      state_d = ST_ARMED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      base_q  <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      base_q  <= base_d;
      left_q  <= left_d;
    end
  end

  assign state    = state_q;
  assign wr_addr  = ptr_q;
  assign base_ptr = base_q;

  // R6: idle stays idle unless armed by the bus
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !arm_req) |=> (state_q == ST_IDLE));
  // R5: a stop always returns to idle
  p_stop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (state_q == ST_IDLE));
  // R9: capture counts down one entry per cycle
  p_left_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CAPT && !stop_req && left_q != AW'(1))
      |=> (state_q == ST_CAPT && left_q == $past(left_q) - 1'b1));
  // R9: last entry written leads to done
  p_capt_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CAPT && !stop_req && left_q == AW'(1)) |=> (state_q == ST_DONE));
endmodule

// File: rtl/la_core.sv
module la_core #(
  parameter logic [15:0] BASE_ADDR = 16'h0100,
  parameter int          DEPTH     = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        probe_a,
  input  logic        probe_b,
  input  logic        probe_c,
  input  logic [3:0]  probe_d,
  input  logic [15:0] in_addr,
  input  logic [15:0] in_wdata,
  input  logic [15:0] in_rdata,
  input  logic        in_we,
  input  logic        in_vld,
  output logic [15:0] out_addr,
  output logic [15:0] out_wdata,
  output logic [15:0] out_rdata,
  output logic        out_we,
  output logic        out_vld
);
  import la_pkg::*;
  localparam int AW   = $clog2(DEPTH);
  localparam int NREG = 2 * NPROBE;
  localparam int SPAN = NCFG + DEPTH;

  logic [15:0]   off, rd_val, loc_q, loc_d;
  logic [15:0]   cfg_q [NREG];
  logic [15:0]   cfg_d [NREG];
  logic          in_rng, wr_hit, st_wr, arm_req, stop_req, trig;
  logic [NPROBE-1:0] en, hit;
  logic [SW-1:0] smp, buf_rdata;
  logic [AW-1:0] wr_addr, base_ptr, rd_idx;
  logic [15:0]   boff;
  logic          wr_en;
  st_e           state;

  assign off      = in_addr - BASE_ADDR;
  assign in_rng   = (32'(off) < SPAN);
  assign wr_hit   = in_vld && in_we && in_rng;
  assign st_wr    = wr_hit && (off == 16'd0);
  assign arm_req  = st_wr && (in_wdata == 16'd1);
  assign stop_req = st_wr && (in_wdata == 16'd0);
  assign smp      = {probe_d, probe_c, probe_b, probe_a};

  // configuration registers
  always_comb begin
    loc_d = loc_q;
    for (int k = 0; k < NREG; k++) cfg_d[k] = cfg_q[k];
    if (wr_hit && off == 16'd1) loc_d = in_wdata;
    for (int k = 0; k < NREG; k++)
      if (wr_hit && off == 16'(2 + k)) cfg_d[k] = in_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q <= '0;
      for (int k = 0; k < NREG; k++) cfg_q[k] <= '0;
    end else if (wr_hit) begin
      loc_q <= loc_d;
      for (int k = 0; k < NREG; k++) cfg_q[k] <= cfg_d[k];
    end
  end

  // per-probe comparators
  for (genvar k = 0; k < NPROBE; k++) begin : g_cmp
    la_cmp #(.W(pw(k))) u_cmp (
      .op  (cfg_q[2*k]),
      .arg (cfg_q[2*k+1][pw(k)-1:0]),
      .val (smp[poff(k) +: pw(k)]),
      .en  (en[k]),
      .hit (hit[k])
    );
  end
  assign trig = &(hit | ~en);

  la_capture #(.DEPTH(DEPTH)) u_capt (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .stop_req(stop_req),
    .trig(trig), .trig_loc(loc_q), .state(state), .wr_en(wr_en),
    .wr_addr(wr_addr), .base_ptr(base_ptr)
  );

  assign boff   = off - 16'(NCFG);
  assign rd_idx = base_ptr + boff[AW-1:0];

  la_buf #(.DEPTH(DEPTH), .W(SW)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(smp),
    .raddr(rd_idx), .rdata(buf_rdata)
  );

  // read mux
  always_comb begin
    rd_val = 16'(buf_rdata);
    if (off == 16'd0) rd_val = 16'(state);
    if (off == 16'd1) rd_val = loc_q;
    for (int k = 0; k < NREG; k++)
      if (off == 16'(2 + k)) rd_val = cfg_q[k];
  end

  // bus output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      out_addr  <= '0;
      out_wdata <= '0;
      out_rdata <= '0;
      out_we    <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_addr  <= in_addr;
        out_wdata <= in_wdata;
        out_we    <= in_we;
        out_rdata <= (in_rng && !in_we) ? rd_val : in_rdata;
      end
    end
  end

  // R1: one forwarded strobe per request
  p_fwd_vld_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  p_no_spur_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  p_fwd_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (out_addr == $past(in_addr)));
  // R2: out-of-window traffic keeps its read data
  p_pass_rdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_rng) |=> (out_rdata == $past(in_rdata)));
  // R3: writes forward the upstream read data
  p_wr_rdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_we) |=> (out_rdata == $past(in_rdata)));
endmodule

// File: tb/la_core_tb.sv
`timescale 1ns/1ps
module la_core_tb;
  localparam logic [15:0] BASE = 16'h0100;

  logic clk, rst_n;
  logic probe_a, probe_b, probe_c;
  logic [3:0] probe_d;
  logic [15:0] in_addr, in_wdata, in_rdata, out_addr, out_wdata, out_rdata;
  logic in_we, in_vld, out_we, out_vld;

  int n_chk = 0, n_err = 0;
  logic [6:0] hist [0:255];
  int hn = 0;
  bit done = 0;

  la_core u_dut (
    .clk(clk), .rst_n(rst_n), .probe_a(probe_a), .probe_b(probe_b),
    .probe_c(probe_c), .probe_d(probe_d), .in_addr(in_addr),
    .in_wdata(in_wdata), .in_rdata(in_rdata), .in_we(in_we), .in_vld(in_vld),
    .out_addr(out_addr), .out_wdata(out_wdata), .out_rdata(out_rdata),
    .out_we(out_we), .out_vld(out_vld)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] a, wd, input logic we, input logic [15:0] rin,
                      output logic [15:0] rout);
    @(negedge clk);
    in_addr = a; in_wdata = wd; in_we = we; in_rdata = rin; in_vld = 1;
    @(negedge clk);
    in_vld = 0;
    chk(out_vld && out_addr == a && out_wdata == wd && out_we == we, "R1",
        {out_vld, out_addr[14:0]}, {1'b1, a[14:0]});
    rout = out_rdata;
  endtask

  task automatic wr(input int o, input logic [15:0] v);
    logic [15:0] r;
    xfer(BASE + 16'(o), v, 1'b1, 16'hA5A5, r);
    chk(r == 16'hA5A5, "R3 write forwards rdata", r, 16'hA5A5);
  endtask

  task automatic rd(input int o, output logic [15:0] v);
    xfer(BASE + 16'(o), 16'h0, 1'b0, 16'h5A5A, v);
  endtask

  task automatic tick(input logic a, b, c, input logic [3:0] d);
    @(negedge clk);
    probe_a = a; probe_b = b; probe_c = c; probe_d = d;
    hist[hn] = {d, c, b, a};
    hn++;
  endtask

  task automatic clr_ops();
    for (int k = 2; k < 10; k++) wr(k, 16'h0);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk(out_vld == 0, "R11 out_vld", 16'(out_vld), 16'h0);
    for (int k = 0; k < 10; k++) begin
      rd(k, v);
      chk(v == 0, "R11 reset word", v, 16'h0);
    end
  endtask

  task automatic t_pass();
    logic [15:0] v;
    xfer(16'h0010, 16'h0001, 1'b0, 16'h1234, v);
    chk(v == 16'h1234, "R2 below window", v, 16'h1234);
    @(negedge clk);
    chk(out_vld == 0, "R1 single strobe", 16'(out_vld), 16'h0);
    xfer(BASE + 16'd138, 16'h0001, 1'b1, 16'h4321, v);
    chk(v == 16'h4321, "R2 above window", v, 16'h4321);
    xfer(BASE, 16'h0001, 1'b1, 16'h0777, v);
    chk(v == 16'h0777, "R2 host offset 0 is in window", v, 16'h0777);
    wr(0, 16'h0);
    rd(0, v);
    chk(v == 0, "R2 no state change", v, 16'h0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(1, 16'hFFBB);
    rd(1, v);
    chk(v == 16'hFFBB, "R4 signed readback", v, 16'hFFBB);
    for (int k = 2; k < 10; k++) wr(k, 16'h1100 + 16'(k));
    for (int k = 2; k < 10; k++) begin
      rd(k, v);
      chk(v == 16'h1100 + 16'(k), "R3 readback", v, 16'h1100 + 16'(k));
    end
    wr(1, 16'h0);
    clr_ops();
  endtask

  task automatic t_idle();
    logic [15:0] v0, v1;
    rd(10, v0);
    wr(2, 16'd8); wr(3, 16'd1);
    for (int i = 0; i < 6; i++) tick(1, 0, 0, 4'h5);
    rd(0, v1);
    chk(v1 == 0, "R6 idle match ignored", v1, 16'h0);
    rd(10, v1);
    chk(v1 == v0, "R6 buffer untouched", v1, v0);
    tick(0, 0, 0, 4'h0);
  endtask

  task automatic t_state();
    logic [15:0] v;
    wr(0, 16'd2); rd(0, v);
    chk(v == 0, "R5 value 2 ignored", v, 16'h0);
    wr(0, 16'd1); rd(0, v);
    chk(v == 1, "R5 arm", v, 16'h1);
    wr(0, 16'd3); rd(0, v);
    chk(v == 1, "R5 value 3 ignored", v, 16'h1);
    wr(0, 16'd0); rd(0, v);
    chk(v == 0, "R5 stop", v, 16'h0);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    wr(1, 16'hFFFB);
    wr(0, 16'd1);
    hn = 0;
    for (int n = 0; n < 160; n++) begin
      logic [7:0] nb = 8'(n);
      tick(n == 20, nb[4], nb[5], nb[3:0]);
    end
    rd(0, v);
    chk(v == 3, "R9 done state", v, 16'h3);
    for (int i = 0; i < 128; i++) begin
      rd(10 + i, v);
      chk(v == 16'(hist[15 + i]), "R9 R10 entry", v, 16'(hist[15 + i]));
    end
    wr(13, 16'h007F);
    rd(13, v);
    chk(v == 16'(hist[18]), "R10 buffer write ignored", v, 16'(hist[18]));
    wr(0, 16'd1); rd(0, v);
    chk(v == 1, "R5 rearm from done", v, 16'h1);
    wr(0, 16'd0);
    wr(1, 16'h0);
    clr_ops();
  endtask

  task automatic t_ops();
    logic [15:0] v;
    // greater-than with positive trigger position
    wr(1, 16'd7); wr(8, 16'd10); wr(9, 16'd5);
    tick(0, 0, 0, 4'd3);
    wr(0, 16'd1);
    for (int i = 0; i < 5; i++) tick(0, 0, 0, 4'd3);
    rd(0, v);
    chk(v == 1, "R7 gt holds off", v, 16'h1);
    for (int i = 0; i < 140; i++) tick(0, 0, 0, 4'd9);
    rd(0, v);
    chk(v == 3, "R7 gt fires", v, 16'h3);
    rd(10, v);
    chk(v == 16'd72, "R9 positive position acts as zero", v, 16'd72);
    wr(0, 16'd0); wr(1, 16'h0);
    // less-than
    wr(8, 16'd11);
    tick(0, 0, 0, 4'd9);
    wr(0, 16'd1);
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 4'd9);
    rd(0, v);
    chk(v == 1, "R7 lt holds off", v, 16'h1);
    tick(0, 0, 0, 4'd2);
    rd(0, v);
    chk(v == 2, "R7 lt fires", v, 16'h2);
    wr(0, 16'd0);
    // not-equal
    wr(8, 16'd9); wr(9, 16'd4);
    tick(0, 0, 0, 4'd4);
    wr(0, 16'd1);
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 4'd4);
    rd(0, v);
    chk(v == 1, "R7 ne holds off", v, 16'h1);
    tick(0, 0, 0, 4'd6);
    rd(0, v);
    chk(v == 2, "R7 ne fires", v, 16'h2);
    wr(0, 16'd0);
    // unknown code disables probe d
    wr(8, 16'd5); wr(9, 16'd0);
    wr(2, 16'd8); wr(3, 16'd1);
    tick(0, 0, 0, 4'd4);
    wr(0, 16'd1);
    for (int i = 0; i < 3; i++) tick(0, 0, 0, 4'd4);
    rd(0, v);
    chk(v == 1, "R7 eq holds off", v, 16'h1);
    tick(1, 0, 0, 4'd4);
    rd(0, v);
    chk(v == 2, "R7 unknown code disabled", v, 16'h2);
    wr(0, 16'd0);
    clr_ops();
  endtask

  task automatic t_and();
    logic [15:0] v;
    wr(2, 16'd8); wr(3, 16'd1); wr(4, 16'd8); wr(5, 16'd1);
    tick(1, 0, 0, 4'd0);
    wr(0, 16'd1);
    for (int i = 0; i < 5; i++) tick(1, 0, 0, 4'd0);
    rd(0, v);
    chk(v == 1, "R8 partial match holds off", v, 16'h1);
    tick(1, 1, 0, 4'd0);
    rd(0, v);
    chk(v == 2, "R8 full match fires", v, 16'h2);
    wr(0, 16'd0);
    clr_ops();
    tick(0, 0, 0, 4'd0);
    wr(0, 16'd1);
    rd(0, v);
    chk(v == 2, "R8 no probe enabled fires at once", v, 16'h2);
    wr(0, 16'd0);
  endtask

  initial begin
    rst_n = 0; in_vld = 0; in_we = 0; in_addr = 0; in_wdata = 0; in_rdata = 0;
    probe_a = 0; probe_b = 0; probe_c = 0; probe_d = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pass();
    t_regs();
    t_idle();
    t_state();
    t_capture();
    t_ops();
    t_and();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule